// File: doc/BRIEF.md
# Timer Trigger Output Selector

This block forms the trigger outputs of a general-purpose timer. A control register holds two mode fields. Each field picks one source and drives it, registered, onto its own trigger line. The sources are:

- three counter events: counter reset, counter enable and update;
- six compare reference levels;
- single-cycle pulses formed from edges of chosen compare references.

Downstream logic, such as converter start inputs or the slave port of another timer, uses these lines to synchronise with the counter.

The primary line has a 3-bit field, so it offers the first eight modes. The secondary line has a 4-bit field and offers all sixteen. Its extra modes add the fifth and sixth references and six edge-combining modes. The secondary line is optional. When an instance is built without it, its field cannot be written and reads as zero. Software can therefore find out whether the line exists by writing all ones to the field and reading it back.

Top module: `trg_out_sel`

## Requirements
- R1: While reset is asserted, both trigger outputs are 0 and the control register reads 0.
- R2: The primary mode occupies control register bits 6:4 and the secondary mode occupies bits 23:20. All other bits ignore writes and read 0. A write on a clock edge selects the new mode for the output value formed at the following edge.
- R3: When the instance is built without the secondary line, bits 23:20 read 0 after any write and the secondary output stays 0.
- R4: Modes 0 (counter reset), 1 (counter enable) and 2 (update) copy the selected one-cycle event to the output, one clock later.
- R5: Mode 3 gives a one-cycle pulse, one clock after each rising edge of reference 1.
- R6: Modes 4 to 9 copy reference 1 to reference 6 respectively to the output, one clock later.
- R7: Mode 10 gives a one-cycle pulse on every edge of reference 4, rising or falling. Mode 11 does the same for reference 6. Edges of the other references have no effect.
- R8: Mode 12 pulses on a rising edge of reference 4 or a rising edge of reference 6. Mode 13 pulses on a rising edge of reference 4 or a falling edge of reference 6.
- R9: Mode 14 pulses on a rising edge of reference 5 or a rising edge of reference 6. Mode 15 pulses on a rising edge of reference 5 or a falling edge of reference 6.
- R10: Each edge pulse lasts exactly one cycle. When two selected edges fall in the same cycle, the output gives a single one-cycle pulse.
- R11: The two mode fields act independently. Each output follows only its own field, even when both fields select the same reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 32 | Control register write data |
| reg_rdata_o | output | 32 | Control register read data |
| cnt_rst_i | input | 1 | Counter reset event, one cycle |
| cnt_en_i | input | 1 | Counter enable event, one cycle |
| cnt_upd_i | input | 1 | Counter update event, one cycle |
| oc_ref_i | input | 6 | Compare reference levels; bit 0 is reference 1 |
| trg_o | output | 1 | Primary trigger output |
| trg2_o | output | 1 | Secondary trigger output |

## Verification
Several assertions compare an output with an input one cycle earlier. For these to hold, the inputs must be quiet while reset is asserted: no events, and all references low. The mode must also be unchanged across the two edges being compared. The stimulus meets these conditions. It holds every reference low during reset and changes inputs only on the falling clock edge. It returns every reference to low before each register write, and keeps events and references unchanged during the write cycle and the cycle after it.

// File: rtl/trg_sel_pkg.sv
package trg_sel_pkg;

  localparam int NUM_REF = 6;
  localparam int NUM_EVT = 3;
  localparam int MODE_W  = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_RST     = 4'd0,
    MODE_EN      = 4'd1,
    MODE_UPD     = 4'd2,
    MODE_CMP_PLS = 4'd3,
    MODE_LVL1    = 4'd4,
    MODE_LVL2    = 4'd5,
    MODE_LVL3    = 4'd6,
    MODE_LVL4    = 4'd7,
    MODE_LVL5    = 4'd8,
    MODE_LVL6    = 4'd9,
    MODE_E4_ANY  = 4'd10,
    MODE_E6_ANY  = 4'd11,
    MODE_R4_R6   = 4'd12,
    MODE_R4_F6   = 4'd13,
    MODE_R5_R6   = 4'd14,
    MODE_R5_F6   = 4'd15
  } trg_mode_e;

  typedef struct packed {
    logic upd;
    logic en;
    logic rst;
  } trg_evt_t;

endpackage

// File: rtl/trg_edge_det.sv
module trg_edge_det #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

  // R10: a level cannot rise on two consecutive cycles
  a_r10_no_back_to_back_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o & $past(rise_o)) == '0);

  // R10: a level cannot fall on two consecutive cycles
  a_r10_no_back_to_back_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o & $past(fall_o)) == '0);

endmodule

// File: rtl/trg_out_mux.sv
module trg_out_mux
  import trg_sel_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int N_REF = NUM_REF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] mode_i,
  input  trg_evt_t         evt_i,
  input  logic [N_REF-1:0] lvl_i,
  input  logic [N_REF-1:0] rise_i,
  input  logic [N_REF-1:0] fall_i,
  output logic             trg_o
);

  localparam int LVL_BASE = 4;

  trg_mode_e    mode_w;
  logic [2:0]   evt_bits;
  logic         trg_d;
  logic         trg_q;

  assign mode_w   = trg_mode_e'(MODE_W'(mode_i));
  assign evt_bits = {evt_i.upd, evt_i.en, evt_i.rst};

  always_comb begin
    unique case (mode_w)
      MODE_RST:     trg_d = evt_i.rst;
      MODE_EN:      trg_d = evt_i.en;
      MODE_UPD:     trg_d = evt_i.upd;
      MODE_CMP_PLS: trg_d = rise_i[0];
      MODE_LVL1:    trg_d = lvl_i[0];
      MODE_LVL2:    trg_d = lvl_i[1];
      MODE_LVL3:    trg_d = lvl_i[2];
      MODE_LVL4:    trg_d = lvl_i[3];
      MODE_LVL5:    trg_d = lvl_i[4];
      MODE_LVL6:    trg_d = lvl_i[5];
      MODE_E4_ANY:  trg_d = rise_i[3] | fall_i[3];
      MODE_E6_ANY:  trg_d = rise_i[5] | fall_i[5];
      MODE_R4_R6:   trg_d = rise_i[3] | rise_i[5];
      MODE_R4_F6:   trg_d = rise_i[3] | fall_i[5];
      MODE_R5_R6:   trg_d = rise_i[4] | rise_i[5];
      MODE_R5_F6:   trg_d = rise_i[4] | fall_i[5];
      default:      trg_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trg_q <= 1'b0;
    else         trg_q <= trg_d;
  end

  assign trg_o = trg_q;

  // edge-detector outputs that no mode selects
  logic unused_edges;
  assign unused_edges = ^{rise_i[2:1], fall_i[2:0], fall_i[4]};

  // R4: event modes forward the selected event one cycle later
  a_r4_event_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w <= MODE_UPD && $stable(mode_w)) |-> trg_q == $past(evt_bits[mode_w[1:0]]));

  // R6: level modes follow the selected reference one cycle later
  a_r6_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w >= MODE_LVL1 && mode_w <= MODE_LVL6 && $stable(mode_w))
      |-> trg_q == $past(lvl_i[3'(mode_w - 4'(LVL_BASE))]));

  // R10: an edge-mode pulse needs an edge in the previous cycle
  a_r10_pulse_has_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w >= MODE_E4_ANY && $stable(mode_w) && trg_q) |-> $past(|{rise_i, fall_i}));

endmodule

// File: rtl/trg_ctrl_reg.sv
module trg_ctrl_reg #(
  parameter int REG_W   = 32,
  parameter int LEG_W   = 3,
  parameter int LEG_LSB = 4,
  parameter int EXT_W   = 4,
  parameter int EXT_LSB = 20,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [LEG_W-1:0] leg_mode_o,
  output logic [EXT_W-1:0] ext_mode_o
);

  logic [LEG_W-1:0] leg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   leg_q <= '0;
    else if (we_i) leg_q <= wdata_i[LEG_LSB +: LEG_W];
  end

  generate
    if (HAS_EXT) begin : g_ext
      logic [EXT_W-1:0] ext_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   ext_q <= '0;
        else if (we_i) ext_q <= wdata_i[EXT_LSB +: EXT_W];
      end
      assign ext_mode_o = ext_q;

      // R2: extended field captures the written value
      a_r2_ext_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> ext_mode_o == $past(wdata_i[EXT_LSB +: EXT_W]));
    end else begin : g_no_ext
      // R3: field absent, ties to zero
      assign ext_mode_o = '0;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    rdata_o[LEG_LSB +: LEG_W] = leg_q;
    rdata_o[EXT_LSB +: EXT_W] = ext_mode_o;
  end

  assign leg_mode_o = leg_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  // R2: legacy field captures the written value
  a_r2_leg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> leg_mode_o == $past(wdata_i[LEG_LSB +: LEG_W]));

  // R2: legacy field holds without a write
  a_r2_leg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(leg_mode_o));

endmodule

// File: rtl/trg_out_sel.sv
module trg_out_sel
  import trg_sel_pkg::*;
#(
  parameter bit HAS_TRG2 = 1'b1,
  parameter int REG_W    = 32,
  parameter int LEG_W    = 3,
  parameter int LEG_LSB  = 4,
  parameter int EXT_W    = MODE_W,
  parameter int EXT_LSB  = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               cnt_rst_i,
  input  logic               cnt_en_i,
  input  logic               cnt_upd_i,
  input  logic [NUM_REF-1:0] oc_ref_i,
  output logic               trg_o,
  output logic               trg2_o
);

  localparam logic [REG_W-1:0] FIELD_MASK =
    (((REG_W)'(1) << LEG_W) - 1) << LEG_LSB | (((REG_W)'(1) << EXT_W) - 1) << EXT_LSB;

  logic [LEG_W-1:0]   leg_mode;
  logic [EXT_W-1:0]   ext_mode;
  logic [NUM_REF-1:0] rise, fall;
  trg_evt_t           evt;

  assign evt = '{upd: cnt_upd_i, en: cnt_en_i, rst: cnt_rst_i};

  trg_ctrl_reg #(
    .REG_W(REG_W), .LEG_W(LEG_W), .LEG_LSB(LEG_LSB),
    .EXT_W(EXT_W), .EXT_LSB(EXT_LSB), .HAS_EXT(HAS_TRG2)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .leg_mode_o (leg_mode),
    .ext_mode_o (ext_mode)
  );

  trg_edge_det #(.N(NUM_REF)) i_edge (
    .clk_i, .rst_ni,
    .lvl_i  (oc_ref_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  trg_out_mux #(.SEL_W(LEG_W), .N_REF(NUM_REF)) i_mux_leg (
    .clk_i, .rst_ni,
    .mode_i (leg_mode),
    .evt_i  (evt),
    .lvl_i  (oc_ref_i),
    .rise_i (rise),
    .fall_i (fall),
    .trg_o  (trg_o)
  );

  generate
    if (HAS_TRG2) begin : g_trg2
      trg_out_mux #(.SEL_W(EXT_W), .N_REF(NUM_REF)) i_mux_ext (
        .clk_i, .rst_ni,
        .mode_i (ext_mode),
        .evt_i  (evt),
        .lvl_i  (oc_ref_i),
        .rise_i (rise),
        .fall_i (fall),
        .trg_o  (trg2_o)
      );
    end else begin : g_no_trg2
      assign trg2_o = 1'b0;
      logic unused_ext;
      assign unused_ext = ^ext_mode;
    end
  endgenerate

  // R2: bits outside both fields read zero
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~FIELD_MASK) == '0);

  // R1: immediate check of reset state
  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_rdata: assert (reg_rdata_o == '0 || $isunknown(reg_rdata_o));
    end
  end

endmodule

// File: tb/test_trg_out_sel.sv
module test_trg_out_sel;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, lite_rdata;
  logic        cnt_rst = 1'b0, cnt_en = 1'b0, cnt_upd = 1'b0;
  logic [5:0]  oc_ref = '0;
  logic        trg, trg2, lite_trg, lite_trg2;

  always #(CLK_P/2) clk = ~clk;

  trg_out_sel i_trg_out_sel (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .cnt_rst_i(cnt_rst), .cnt_en_i(cnt_en), .cnt_upd_i(cnt_upd),
    .oc_ref_i(oc_ref), .trg_o(trg), .trg2_o(trg2)
  );

  trg_out_sel #(.HAS_TRG2(1'b0)) i_trg_out_sel_lite (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(lite_rdata), .cnt_rst_i(cnt_rst), .cnt_en_i(cnt_en), .cnt_upd_i(cnt_upd),
    .oc_ref_i(oc_ref), .trg_o(lite_trg), .trg2_o(lite_trg2)
  );

  typedef struct {
    bit    chk;
    logic  trg;
    logic  trg2;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wd(input int leg, input int ext);
    return (32'(ext) << 20) | (32'(leg) << 4);
  endfunction

  // driver: apply one cycle of stimulus, queue expectation for the next edge
  task automatic drive(input logic [5:0] r, input logic [2:0] ev,
                       input bit c, input logic t, input logic t2, input string tag);
    exp_t e;
    @(negedge clk);
    reg_we = 1'b0;
    oc_ref = r;
    {cnt_upd, cnt_en, cnt_rst} = ev;
    e.chk = c; e.trg = t; e.trg2 = t2; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic set_modes(input logic [31:0] w, input logic [31:0] exp_main,
                           input logic [31:0] exp_lite);
    exp_t e;
    e.chk = 1'b0; e.trg = 1'b0; e.trg2 = 1'b0; e.tag = "wr";
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = w;
    {cnt_upd, cnt_en, cnt_rst} = '0;
    q.push_back(e);
    @(negedge clk);
    reg_we = 1'b0;
    q.push_back(e);
    check("R2 rdata", rdata, exp_main);
    check("R3 lite rdata", lite_rdata, exp_lite);
  endtask

  // monitor: compare once the registered outputs settle after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        if (e.chk) begin
          check({e.tag, " trg"}, 32'(trg), 32'(e.trg));
          check({e.tag, " trg2"}, 32'(trg2), 32'(e.trg2));
        end
        check("R3 lite trg2", 32'(lite_trg2), 32'(0));
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  localparam logic [5:0] B0 = 6'b000001, B1 = 6'b000010, B3 = 6'b001000,
                         B4 = 6'b010000, B5 = 6'b100000, Z = 6'b000000;
  localparam logic [2:0] EV0 = 3'b000, EV_RST = 3'b001, EV_EN = 3'b010, EV_UPD = 3'b100;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 trg", 32'(trg), 32'(0));
    check("R1 trg2", 32'(trg2), 32'(0));
    check("R1 rdata", rdata, 32'h0);
    rst_n = 1'b1;

    // R2/R3: all-ones probe, reserved bits and bit 7 ignored
    set_modes(32'hFFFF_FFFF, 32'h00F0_0070, 32'h0000_0070);

    // R4 event modes
    set_modes(wd(2, 0), wd(2, 0), wd(2, 0));
    drive(Z, EV_UPD | EV_RST, 1, 1, 1, "R4 upd/rst");
    drive(Z, EV0, 1, 0, 0, "R4 idle");
    drive(Z, EV_EN, 1, 0, 0, "R4 en unselected");
    set_modes(wd(1, 2), wd(1, 2), wd(1, 0));
    drive(Z, EV_EN, 1, 1, 0, "R4 en");
    drive(Z, EV_UPD, 1, 0, 1, "R4 upd");
    drive(Z, EV0, 1, 0, 0, "R4 idle2");

    // R5 compare pulse and R6 levels
    set_modes(wd(3, 4), wd(3, 4), wd(3, 0));
    drive(B0, EV0, 1, 1, 1, "R5 rise / R6 lvl1");
    drive(B0, EV0, 1, 0, 1, "R5 one pulse / R6 hold");
    drive(Z, EV0, 1, 0, 0, "R5/R6 low");
    set_modes(wd(7, 9), wd(7, 9), wd(7, 0));
    drive(B3, EV0, 1, 1, 0, "R6 lvl4");
    drive(B5, EV0, 1, 0, 1, "R6 lvl6");
    drive(Z, EV0, 1, 0, 0, "R6 low");
    set_modes(wd(7, 8), wd(7, 8), wd(7, 0));
    drive(B4, EV0, 1, 0, 1, "R6 lvl5");
    drive(Z, EV0, 1, 0, 0, "R6 lvl5 low");

    // R7 both-edge modes
    set_modes(wd(0, 10), wd(0, 10), wd(0, 0));
    drive(B3, EV0, 1, 0, 1, "R7 m10 rise");
    drive(B3, EV0, 1, 0, 0, "R7 m10 hold");
    drive(Z, EV0, 1, 0, 1, "R7 m10 fall");
    drive(Z, EV0, 1, 0, 0, "R7 m10 idle");
    set_modes(wd(0, 11), wd(0, 11), wd(0, 0));
    drive(B5, EV0, 1, 0, 1, "R7 m11 rise");
    drive(Z, EV0, 1, 0, 1, "R7 m11 fall");
    drive(Z, EV0, 1, 0, 0, "R7 m11 idle");
    drive(B3, EV0, 1, 0, 0, "R7 m11 ref4 ignored");
    drive(Z, EV0, 1, 0, 0, "R7 m11 ref4 fall ignored");

    // R8 modes 12/13
    set_modes(wd(0, 12), wd(0, 12), wd(0, 0));
    drive(B3, EV0, 1, 0, 1, "R8 m12 r4");
    drive(B3 | B5, EV0, 1, 0, 1, "R8 m12 r6");
    drive(B3, EV0, 1, 0, 0, "R8 m12 f6 ignored");
    drive(Z, EV0, 1, 0, 0, "R8 m12 f4 ignored");
    drive(B3 | B5, EV0, 1, 0, 1, "R10 m12 coincident");
    drive(B3 | B5, EV0, 1, 0, 0, "R10 m12 single");
    drive(Z, EV0, 1, 0, 0, "R8 m12 idle");
    set_modes(wd(0, 13), wd(0, 13), wd(0, 0));
    drive(B5, EV0, 1, 0, 0, "R8 m13 r6 ignored");
    drive(Z, EV0, 1, 0, 1, "R8 m13 f6");
    drive(B3, EV0, 1, 0, 1, "R8 m13 r4");
    drive(B5, EV0, 1, 0, 0, "R8 m13 f4 r6 ignored");
    drive(B3, EV0, 1, 0, 1, "R10 m13 coincident");
    drive(B3, EV0, 1, 0, 0, "R10 m13 single");
    drive(Z, EV0, 1, 0, 0, "R8 m13 idle");

    // R9 modes 14/15
    set_modes(wd(0, 14), wd(0, 14), wd(0, 0));
    drive(B4, EV0, 1, 0, 1, "R9 m14 r5");
    drive(B4 | B5, EV0, 1, 0, 1, "R9 m14 r6");
    drive(B3, EV0, 1, 0, 0, "R9 m14 falls/r4 ignored");
    drive(Z, EV0, 1, 0, 0, "R9 m14 idle");
    drive(B4 | B5, EV0, 1, 0, 1, "R10 m14 coincident");
    drive(B4 | B5, EV0, 1, 0, 0, "R10 m14 single");
    drive(Z, EV0, 1, 0, 0, "R9 m14 idle2");
    set_modes(wd(0, 15), wd(0, 15), wd(0, 0));
    drive(B5, EV0, 1, 0, 0, "R9 m15 r6 ignored");
    drive(Z, EV0, 1, 0, 1, "R9 m15 f6");
    drive(B4, EV0, 1, 0, 1, "R9 m15 r5");
    drive(Z, EV0, 1, 0, 0, "R9 m15 f5 ignored");

    // R11 independent fields
    set_modes(wd(5, 3), wd(5, 3), wd(5, 0));
    drive(B0 | B1, EV0, 1, 1, 1, "R11 lvl2 / cmp pulse");
    drive(B0 | B1, EV0, 1, 1, 0, "R11 hold");
    drive(Z, EV0, 1, 0, 0, "R11 low");
    set_modes(wd(4, 4), wd(4, 4), wd(4, 0));
    drive(B0, EV0, 1, 1, 1, "R11 same ref");
    drive(Z, EV0, 1, 0, 0, "R11 same ref low");

    drive(Z, EV0, 0, 0, 0, "drain");
    drive(Z, EV0, 0, 0, 0, "drain");
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule